// File: doc/BRIEF.md
# Serial 5B/4B Receive Aligner and Frame Decoder

This block sits after the descrambler in a 100 Mb/s receive path. It takes one descrambled line bit per clock, with no knowledge of where 5-bit code-groups begin. It also takes a link-good level and a signal-present level. While hunting, it watches a sliding window of recent bits. The window must hold a run of idle ones followed by the start pair: 11000 then 10001. When the window matches, the block fixes the code-group boundary right after the pair.

Once locked, the block cuts the stream into 5-bit symbols and translates each symbol to a 4-bit nibble. It presents the nibbles on an MII-style receive port. The two start symbols become two preamble nibbles, and receive-valid rises with the first of them. The end pair (01101 then 00111) closes the frame, and so does loss of link or of signal. After the frame closes, the aligner hunts again for idle followed by the start pair.

Each nibble is marked by a one-clock strobe. Inside a frame the strobes come every five clocks. Data leave one symbol period after their symbol has arrived, because the second preamble nibble takes the first data slot.

Top module: `rx_sym_framer`

## Requirements
- R1: A frame starts when the last 20 received bits are ten ones, then 11000, then 10001, with link_ok and sig_det both high. This holds whatever the number of idle bits before the pair. Each code-group is sent first bit as MSB. The start strobe comes one clock after the last bit of the pair has been shifted in.
- R2: The start pair is not accepted when fewer than ten ones immediately precede it, and no strobe is produced.
- R3: rx_dv rises together with the first strobe. The first two strobes of a frame each carry rxd = 0101 with rx_err low.
- R4: The data symbols decode by the standard table, with rxd[0] the nibble LSB. For example, 11110 gives 0000, 01001 gives 0001 and 11101 gives 1111. Each data nibble appears, in order, after the two preamble nibbles.
- R5: Within a frame, rx_stb pulses for exactly one clock every five clocks, and only while rx_dv is high.
- R6: When 01101 is followed by 00111, rx_dv falls at the slot of the 00111 symbol. Neither of the two end symbols yields a nibble, and the last data nibble is still delivered.
- R7: A symbol inside a frame that is neither a data code nor the end pair yields a nibble with rx_err high. This includes 01101 when it is not followed by 00111. The nibble value is then unspecified.
- R8: If link_ok or sig_det is low at a clock edge while rx_dv is high, rx_dv is low after that edge. No further strobe follows until a new idle-plus-start sequence arrives. This abort wins over a symbol slot that falls on the same edge.
- R9: A start sequence that completes while link_ok or sig_det is low is ignored.
- R10: After reset, rx_dv, rx_stb, rx_err and rxd are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Descrambled serial line bit |
| link_ok | input | 1 | Link-good level; low aborts a frame |
| sig_det | input | 1 | Signal-present level; low aborts a frame |
| rxd | output | 4 | Decoded nibble, bit 0 is the LSB |
| rx_dv | output | 1 | Receive data valid, framed from start pair to end pair |
| rx_err | output | 1 | Nibble came from an invalid symbol |
| rx_stb | output | 1 | One-clock strobe marking a new nibble |

## Verification
A loss of link or signal can reach the block on the very edge where a completed symbol is due to emit its nibble. The bench provokes this by lowering link_ok for exactly the bit that is shifted on the second symbol slot of a frame. It expects only the first preamble nibble and no second one, so the abort must have taken priority over the slot. A second case lowers sig_det two bits later, after the slot. There the second preamble nibble must appear, showing that the abort is tied to the edge and not to the symbol.

// File: rtl/symdec_pkg.sv
package symdec_pkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;
  localparam int PAIR_W = 2 * SYM_W;

  localparam logic [SYM_W-1:0] SYM_J = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_T = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_R = 5'b00111;
  localparam logic [NIB_W-1:0] PRE_NIB = 4'b0101;

  typedef struct packed {
    logic             bad;
    logic [NIB_W-1:0] nib;
  } nib_t;

  function automatic nib_t sym_to_nib(input logic [SYM_W-1:0] code);
    nib_t r;
    r.bad = 1'b0;
    case (code)
      5'b11110: r.nib = 4'h0;
      5'b01001: r.nib = 4'h1;
      5'b10100: r.nib = 4'h2;
      5'b10101: r.nib = 4'h3;
      5'b01010: r.nib = 4'h4;
      5'b01011: r.nib = 4'h5;
      5'b01110: r.nib = 4'h6;
      5'b01111: r.nib = 4'h7;
      5'b10010: r.nib = 4'h8;
      5'b10011: r.nib = 4'h9;
      5'b10110: r.nib = 4'hA;
      5'b10111: r.nib = 4'hB;
      5'b11010: r.nib = 4'hC;
      5'b11011: r.nib = 4'hD;
      5'b11100: r.nib = 4'hE;
      5'b11101: r.nib = 4'hF;
      default: begin
        r.nib = '0;
        r.bad = 1'b1;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sym_shift_align.sv
module sym_shift_align
  import symdec_pkg::*;
#(
  parameter int IDLE_BITS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  output logic [SYM_W-1:0] sym,
  output logic             jk_hit
);
  localparam int WIN = IDLE_BITS + PAIR_W;
  localparam logic [PAIR_W-1:0] JK_PAT = {SYM_J, SYM_K};

  logic [WIN-1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else     win_q <= {win_q[WIN-2:0], bit_in};
  end

  assign sym    = win_q[SYM_W-1:0];
  assign jk_hit = (win_q[PAIR_W-1:0] == JK_PAT) && (&win_q[WIN-1:PAIR_W]);
endmodule

// File: rtl/sym_slot_timer.sv
module sym_slot_timer
  import symdec_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic slot
);
  localparam int CNT_W = $clog2(SYM_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      slot  <= 1'b0;
    end else if (start) begin
      cnt_q <= CNT_W'(1);
      slot  <= 1'b0;
    end else if (run) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        slot  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        slot  <= 1'b0;
      end
    end else begin
      cnt_q <= '0;
      slot  <= 1'b0;
    end
  end
endmodule

// File: rtl/sym_lookup.sv
module sym_lookup
  import symdec_pkg::*;
(
  input  logic [SYM_W-1:0] code,
  output nib_t             dec
);
  always_comb dec = sym_to_nib(code);
endmodule

// File: rtl/rx_sym_framer.sv
module rx_sym_framer
  import symdec_pkg::*;
#(
  parameter int IDLE_BITS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             link_ok,
  input  logic             sig_det,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv,
  output logic             rx_err,
  output logic             rx_stb
);
  logic [SYM_W-1:0] sym;
  logic             jk_hit;
  logic             slot;
  logic             in_frame;
  logic             pend_t;
  logic             line_ok;
  logic             start;
  nib_t             dec;
  nib_t             held;

  assign line_ok = link_ok & sig_det;
  assign start   = !in_frame && jk_hit && line_ok;

  sym_shift_align #(.IDLE_BITS(IDLE_BITS)) u_align (
    .clk   (clk),
    .rst   (rst),
    .bit_in(bit_in),
    .sym   (sym),
    .jk_hit(jk_hit)
  );

  sym_slot_timer u_timer (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .run  (in_frame),
    .slot (slot)
  );

  sym_lookup u_lut (
    .code(sym),
    .dec (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      pend_t   <= 1'b0;
      held     <= '0;
      rx_dv    <= 1'b0;
      rx_stb   <= 1'b0;
      rx_err   <= 1'b0;
      rxd      <= '0;
    end else begin
      rx_stb <= 1'b0;
      if (!in_frame) begin
        if (start) begin
          in_frame <= 1'b1;
          pend_t   <= 1'b0;
          held     <= '{bad: 1'b0, nib: PRE_NIB};
          rx_dv    <= 1'b1;
          rx_stb   <= 1'b1;
          rx_err   <= 1'b0;
          rxd      <= PRE_NIB;
        end
      end else if (!line_ok) begin
        in_frame <= 1'b0;
        pend_t   <= 1'b0;
        rx_dv    <= 1'b0;
      end else if (slot) begin
        if (pend_t && (sym == SYM_R)) begin
          in_frame <= 1'b0;
          pend_t   <= 1'b0;
          rx_dv    <= 1'b0;
        end else begin
          rx_stb <= 1'b1;
          if (pend_t) begin
            rxd    <= '0;
            rx_err <= 1'b1;
          end else begin
            rxd    <= held.nib;
            rx_err <= held.bad;
          end
          if (sym == SYM_T) begin
            pend_t <= 1'b1;
          end else begin
            pend_t <= 1'b0;
            held   <= dec;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rx_sym_framer_chk.sv
module rx_sym_framer_chk
  import symdec_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             link_ok,
  input logic             sig_det,
  input logic [NIB_W-1:0] rxd,
  input logic             rx_dv,
  input logic             rx_err,
  input logic             rx_stb
);
  logic [7:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)         gap_q <= 8'hFF;
    else if (rx_stb) gap_q <= '0;
    else if (gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
  end

  // R3
  preamble_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_dv) |-> (rx_stb && rxd == PRE_NIB && !rx_err));

  // R5
  strobe_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    rx_stb |-> rx_dv);

  // R5
  strobe_cadence_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_stb && $past(rx_dv)) |-> (gap_q == 8'd4));

  // R6
  end_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_dv) |-> !rx_stb);

  // R8
  abort_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_dv && !(link_ok && sig_det)) |=> !rx_dv);

  // R9
  no_start_bad_line_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_dv && !(link_ok && sig_det)) |=> !rx_dv);
endmodule

bind rx_sym_framer rx_sym_framer_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .link_ok(link_ok),
  .sig_det(sig_det),
  .rxd    (rxd),
  .rx_dv  (rx_dv),
  .rx_err (rx_err),
  .rx_stb (rx_stb)
);

// File: tb/rx_sym_framer_tb_top.sv
`timescale 1ns/100ps
module rx_sym_framer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b1;
  logic link_ok = 1'b1;
  logic sig_det = 1'b1;
  logic [3:0] rxd;
  logic rx_dv, rx_err, rx_stb;

  always #2.5 clk = ~clk;

  rx_sym_framer dut_i (
    .clk(clk), .rst(rst), .bit_in(bit_in), .link_ok(link_ok), .sig_det(sig_det),
    .rxd(rxd), .rx_dv(rx_dv), .rx_err(rx_err), .rx_stb(rx_stb)
  );

  localparam logic [4:0] CJ = 5'b11000, CK = 5'b10001, CT = 5'b01101, CR = 5'b00111;
  // {5B code, 4B nibble}
  localparam logic [8:0] DTAB [16] = '{
    {5'b11110, 4'h0}, {5'b01001, 4'h1}, {5'b10100, 4'h2}, {5'b10101, 4'h3},
    {5'b01010, 4'h4}, {5'b01011, 4'h5}, {5'b01110, 4'h6}, {5'b01111, 4'h7},
    {5'b10010, 4'h8}, {5'b10011, 4'h9}, {5'b10110, 4'hA}, {5'b10111, 4'hB},
    {5'b11010, 4'hC}, {5'b11011, 4'hD}, {5'b11100, 4'hE}, {5'b11101, 4'hF}};

  int checks = 0, errors = 0, cyc = 0;
  int ncap = 0, nexp = 0, base = 0;
  logic [3:0] cap_nib [256];
  logic       cap_err [256];
  int         cap_cyc [256];
  logic [3:0] exp_nib [64];
  logic       exp_err [64];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rx_stb && ncap < 256) begin
      cap_nib[ncap] = rxd;
      cap_err[ncap] = rx_err;
      cap_cyc[ncap] = cyc;
      ncap = ncap + 1;
    end
  end

  always @(posedge clk) begin
    if (cyc > 60000) begin
      errors++; checks++;
      $display("FAIL R5 watchdog expired: actual cyc=%0d expected <60000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b;
  endtask

  task automatic send_sym(input logic [4:0] c);
    for (int i = 4; i >= 0; i--) send_bit(c[i]);
  endtask

  task automatic send_idle(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic begin_case();
    base = ncap;
    nexp = 0;
  endtask

  task automatic ex(input logic [3:0] n, input logic e);
    exp_nib[nexp] = n;
    exp_err[nexp] = e;
    nexp++;
  endtask

  task automatic end_case(input string req);
    send_idle(16);
    chk(ncap - base == nexp, {req, " nibble count"}, ncap - base, nexp);
    for (int i = 0; i < nexp && i < ncap - base; i++) begin
      if (exp_err[i])
        chk(cap_err[base+i] == 1'b1, {req, " error flag"}, cap_err[base+i], 1);
      else
        chk(cap_err[base+i] == 1'b0 && cap_nib[base+i] == exp_nib[i], {req, " nibble"},
            {cap_err[base+i], cap_nib[base+i]}, exp_nib[i]);
    end
    chk(rx_dv == 1'b0, {req, " rx_dv low after frame"}, rx_dv, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(rx_dv == 0 && rx_stb == 0 && rx_err == 0 && rxd == 4'h0, "R10 reset outputs",
        {rx_dv, rx_stb, rx_err, rxd}, 0);

    // R1 R3 R4 R6: table-driven frame carrying every data code
    begin_case();
    send_idle(12);
    send_sym(CJ); send_sym(CK);
    ex(4'b0101, 0); ex(4'b0101, 0);
    for (int i = 0; i < 16; i++) begin
      send_sym(DTAB[i][8:4]);
      ex(DTAB[i][3:0], 0);
    end
    send_sym(CT); send_sym(CR);
    end_case("R4");
    // R5 cadence of the strobes in that frame
    for (int i = base + 1; i < ncap; i++)
      chk(cap_cyc[i] - cap_cyc[i-1] == 5, "R5 strobe spacing", cap_cyc[i] - cap_cyc[i-1], 5);

    // R1 different bit offset of the idle run
    begin_case();
    send_idle(17);
    send_sym(CJ); send_sym(CK); send_sym(5'b01001); send_sym(CT); send_sym(CR);
    ex(4'b0101, 0); ex(4'b0101, 0); ex(4'h1, 0);
    end_case("R1");

    // R2 only nine ones before the start pair
    begin_case();
    send_bit(1'b0); send_idle(9);
    send_sym(CJ); send_sym(CK); send_sym(5'b11110); send_sym(CT); send_sym(CR);
    end_case("R2");

    // R7 invalid code inside a frame
    begin_case();
    send_idle(12);
    send_sym(CJ); send_sym(CK); send_sym(5'b00000); send_sym(5'b01001);
    send_sym(CT); send_sym(CR);
    ex(4'b0101, 0); ex(4'b0101, 0); ex(4'h0, 1); ex(4'h1, 0);
    end_case("R7");

    // R7 end symbol not followed by its partner
    begin_case();
    send_idle(12);
    send_sym(CJ); send_sym(CK); send_sym(5'b01001); send_sym(CT);
    send_sym(5'b11110); send_sym(CT); send_sym(CR);
    ex(4'b0101, 0); ex(4'b0101, 0); ex(4'h1, 0); ex(4'h0, 1); ex(4'h0, 0);
    end_case("R7");

    // R8 link loss on the same edge as the second symbol slot: abort wins
    begin_case();
    send_idle(12);
    send_sym(CJ); send_sym(CK); send_sym(5'b01001);
    @(negedge clk); bit_in = 1'b1; link_ok = 1'b0;
    @(negedge clk); bit_in = 1'b1; link_ok = 1'b1;
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    send_sym(5'b10100); send_sym(CT); send_sym(CR);
    ex(4'b0101, 0);
    end_case("R8");

    // R8 signal loss two bits after that slot
    begin_case();
    send_idle(12);
    send_sym(CJ); send_sym(CK); send_sym(5'b01001);
    send_bit(1'b1); send_bit(1'b1);
    @(negedge clk); bit_in = 1'b1; sig_det = 1'b0;
    @(negedge clk); bit_in = 1'b1; sig_det = 1'b1;
    send_bit(1'b0);
    send_sym(5'b10100); send_sym(CT); send_sym(CR);
    ex(4'b0101, 0); ex(4'b0101, 0);
    end_case("R8");

    // R9 start sequence while the signal is absent
    begin_case();
    sig_det = 1'b0;
    send_idle(12);
    send_sym(CJ); send_sym(CK); send_sym(5'b01001);
    sig_det = 1'b1;
    send_sym(5'b10100); send_sym(CT); send_sym(CR);
    end_case("R9");

    // R8 recovery: a clean frame after the aborts
    begin_case();
    send_idle(10);
    send_sym(CJ); send_sym(CK); send_sym(5'b11101); send_sym(5'b10010);
    send_sym(CT); send_sym(CR);
    ex(4'b0101, 0); ex(4'b0101, 0); ex(4'hF, 0); ex(4'h8, 0);
    end_case("R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule